// File: doc/BRIEF.md
# Quadrature Position Counter with Index and Delayed Capture

This block turns the two phase signals of an incremental encoder, its once-per-turn reference pulse and an external capture strobe into a position count of parameterised width. All three encoder inputs are synchronised and then debounced by a majority-free agreement filter. The filter samples at a rate that a power-of-two prescaler selects. The cleaned phases are decoded at one, two or four counts per electrical cycle. A swap control reverses the counting sense without rewiring.

The counter can reload a programmed start value when the reference pulse is seen. It can also run as a modulo counter between that start value and a programmed ceiling. The count is copied into two read-only holding outputs: one at each reference pulse, and one a programmed number of clocks after each capture strobe. Seven event flags report reference, illegal transition, compare match, wrap, capture, direction reversal and movement. They are cleared by writing ones, and are masked onto a single interrupt line. The control inputs are meant to be driven by a register wrapper outside this block.

Top module: `qenc_counter`

## Requirements
- R1: Mode code 2 (and the spare code 3) counts on every accepted edge of either phase. The sequence (A,B) = 00, 10, 11, 01, 00 counts up, and the reverse order counts down.
- R2: Mode code 1 counts only on edges of phase A, in the direction given by R1.
- R3: Mode code 0 counts once per full cycle, on an A edge taken while B is low: +1 on 00 to 10, and -1 on 10 to 00.
- R4: With the swap bit set, A and B are exchanged ahead of the decoder, so the R1 up-sequence counts down.
- R5: Filter code k (0..3) accepts an input change only after k+1 consecutive equal samples. A pulse shorter than that leaves the count unchanged.
- R6: Prescaler code p (0..7) takes a filter sample once every 2^p clocks.
- R7: If A and B change in the same sample, flag bit 1 is set and the count holds.
- R8: A rising reference edge copies the current count to `idx_pos` and sets flag bit 0. If reload is enabled, the count is also loaded from `init_val`.
- R9: With wrap enabled, a step up from `max_val` goes to `init_val` and a step down from `init_val` goes to `max_val`. Either wrap sets flag bit 3.
- R10: Flag bit 2 is set when the count after a step equals `cmp_val`.
- R11: The `cap_pos` output takes the count N clocks after the capture edge is seen, where N is `cap_delay`, and flag bit 4 is set at that moment.
- R12: `dir` is 1 after an up step and 0 after a down step. Flag bit 5 is set when `dir` changes, and flag bit 6 on every step.
- R13: A one in `flag_clr` clears that flag (a new event in the same cycle wins). `irq` is high while any flag has its `irq_mask` bit set.
- R14: After reset all outputs are zero. With enable low the count, latches and filters hold. Flags are then zeroed if sticky is clear, or kept (still clearable) if sticky is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Run enable |
| cfg_mode | input | 2 | Counts per cycle: 0 x1, 1 x2, 2/3 x4 |
| cfg_swap | input | 1 | Exchange A and B |
| cfg_filt | input | 2 | Filter depth code |
| cfg_presc | input | 3 | Sample prescaler code |
| cfg_idx_reload | input | 1 | Reload count on reference pulse |
| cfg_wrap_en | input | 1 | Modulo counting between init and max |
| cfg_sticky | input | 1 | Keep flags while disabled |
| max_val | input | CNT_W | Counter ceiling |
| init_val | input | CNT_W | Reload / floor value |
| cmp_val | input | CNT_W | Compare value |
| cap_delay | input | DLY_W | Capture delay in clocks |
| ch_a | input | 1 | Phase A, asynchronous |
| ch_b | input | 1 | Phase B, asynchronous |
| ch_idx | input | 1 | Reference pulse, asynchronous |
| cap_strobe | input | 1 | Capture strobe, asynchronous |
| flag_clr | input | 7 | Write-one-to-clear flag pulses |
| irq_mask | input | 7 | Per-flag interrupt enables |
| pos | output | CNT_W | Live count |
| idx_pos | output | CNT_W | Count held at last reference pulse |
| cap_pos | output | CNT_W | Count held at last capture |
| dir | output | 1 | Last counting direction, 1 = up |
| flags | output | 7 | Event flags |
| irq | output | 1 | Masked OR of flags |

## Verification
With prescaler code 0 and filter code 0, a phase change reaches `pos`, `dir` and the flags on the fourth rising edge after it is driven. Each added filter sample adds one sample period. A capture strobe shows up in `cap_pos` on edge 3 + N. The driver waits a settle time that covers these latencies before it queues an expected item, and the monitor compares the queued items on the following falling edge. The bench also checks that outputs have not yet changed at points inside a latency window: 20 clocks into a divide-by-16, four-sample filter, and 6 clocks into a 5-clock capture delay.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   localparam int NFLAG   = 7;
   localparam int FL_IDX  = 0;
   localparam int FL_QERR = 1;
   localparam int FL_CMP  = 2;
   localparam int FL_WRAP = 3;
   localparam int FL_CAP  = 4;
   localparam int FL_DIR  = 5;
   localparam int FL_MOVE = 6;

   typedef enum logic [1:0] {
      QM_X1  = 2'd0,
      QM_X2  = 2'd1,
      QM_X4  = 2'd2,
      QM_X4B = 2'd3
   } qmode_e;
endpackage

// File: rtl/qenc_prescale.sv
module qenc_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int CW = (1 << SEL_W) - 1;

   logic [CW-1:0] cnt;
   logic [CW:0]   one_sh;
   logic [CW-1:0] mask;

   if (SEL_W < 1) begin : g_bad_sel
      initial $fatal(1, "qenc_prescale: SEL_W must be at least 1");
   end

   assign one_sh = {{CW{1'b0}}, 1'b1} << sel;
   assign mask   = CW'(one_sh - 1'b1);
   assign tick   = &(cnt | ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/qenc_input_filter.sv
module qenc_input_filter #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [SEL_W-1:0] depth,
   input  logic             din,
   output logic             dout
);
   localparam int HW = (1 << SEL_W) - 1;

   logic [1:0]    sync;
   logic [HW-1:0] hist;
   logic          s;
   logic          agree;

   if (SEL_W < 1) begin : g_bad_depth
      initial $fatal(1, "qenc_input_filter: SEL_W must be at least 1");
   end

   assign s = sync[1];

   always_comb begin
      agree = 1'b1;
      for (int i = 0; i < HW; i++) begin
         if (i < int'(depth) && hist[i] != s) agree = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync <= '0;
         hist <= '0;
         dout <= 1'b0;
      end else if (run) begin
         sync <= {sync[0], din};
         if (tick) begin
            hist <= (hist << 1) | HW'(s);
            if (agree) dout <= s;
         end
      end
   end
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
   import qenc_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   run,
   input  logic   a,
   input  logic   b,
   input  qmode_e mode,
   output logic   up,
   output logic   dn,
   output logic   err
);
   logic pa, pb;
   logic ch_a, ch_b, single, fwd, counted;

   assign ch_a   = a ^ pa;
   assign ch_b   = b ^ pb;
   assign single = ch_a ^ ch_b;
   assign fwd    = pb ^ a;

   always_comb begin
      unique case (mode)
         QM_X1:   counted = ch_a & ~b;
         QM_X2:   counted = ch_a;
         default: counted = 1'b1;
      endcase
   end

   assign up  = run & single & counted & fwd;
   assign dn  = run & single & counted & ~fwd;
   assign err = run & ch_a & ch_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa <= 1'b0;
         pb <= 1'b0;
      end else if (run) begin
         pa <= a;
         pb <= b;
      end
   end
endmodule

// File: rtl/qenc_capture.sv
module qenc_capture #(
   parameter int DLY_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             strobe,
   input  logic [DLY_W-1:0] delay,
   output logic             fire
);
   logic [2:0]       sync;
   logic             edge_seen;
   logic             busy;
   logic [DLY_W-1:0] cnt;

   if (DLY_W < 1) begin : g_bad_dly
      initial $fatal(1, "qenc_capture: DLY_W must be at least 1");
   end

   assign edge_seen = sync[1] & ~sync[2];
   assign fire = run & ((edge_seen & ~busy & (delay == '0)) |
                        (busy & (cnt == DLY_W'(1))));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync <= '0;
         busy <= 1'b0;
         cnt  <= '0;
      end else if (run) begin
         sync <= {sync[1:0], strobe};
         if (busy) begin
            if (cnt == DLY_W'(1)) busy <= 1'b0;
            cnt <= cnt - 1'b1;
         end else if (edge_seen && delay != '0) begin
            busy <= 1'b1;
            cnt  <= delay;
         end
      end
   end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
   import qenc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DLY_W  = 32,
   parameter int FILT_W = 2,
   parameter int PSC_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_swap,
   input  logic [FILT_W-1:0] cfg_filt,
   input  logic [PSC_W-1:0]  cfg_presc,
   input  logic              cfg_idx_reload,
   input  logic              cfg_wrap_en,
   input  logic              cfg_sticky,
   input  logic [CNT_W-1:0]  max_val,
   input  logic [CNT_W-1:0]  init_val,
   input  logic [CNT_W-1:0]  cmp_val,
   input  logic [DLY_W-1:0]  cap_delay,
   input  logic              ch_a,
   input  logic              ch_b,
   input  logic              ch_idx,
   input  logic              cap_strobe,
   input  logic [NFLAG-1:0]  flag_clr,
   input  logic [NFLAG-1:0]  irq_mask,
   output logic [CNT_W-1:0]  pos,
   output logic [CNT_W-1:0]  idx_pos,
   output logic [CNT_W-1:0]  cap_pos,
   output logic              dir,
   output logic [NFLAG-1:0]  flags,
   output logic              irq
);
   localparam int NIN = 3;

   if (CNT_W < 2) begin : g_bad_cnt
      initial $fatal(1, "qenc_counter: CNT_W must be at least 2");
   end

   logic             run;
   logic             smp_tick;
   logic [NIN-1:0]   raw_in;
   logic [NIN-1:0]   flt;
   logic             dec_a, dec_b;
   logic             st_up, st_dn, st_err;
   logic             idx_q, idx_hit;
   logic             cap_fire;
   logic [CNT_W-1:0] pos_n;
   logic             wrapped, stepped, reload;
   logic [NFLAG-1:0] fset;

   assign run    = cfg_enable;
   assign raw_in = {ch_idx, ch_b, ch_a};

   qenc_prescale #(.SEL_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(run), .sel(cfg_presc), .tick(smp_tick)
   );

   for (genvar g = 0; g < NIN; g++) begin : g_flt
      qenc_input_filter #(.SEL_W(FILT_W)) u_flt (
         .clk(clk), .rst_n(rst_n), .run(run), .tick(smp_tick),
         .depth(cfg_filt), .din(raw_in[g]), .dout(flt[g])
      );
   end

   assign dec_a = cfg_swap ? flt[1] : flt[0];
   assign dec_b = cfg_swap ? flt[0] : flt[1];

   qenc_step_decode u_dec (
      .clk(clk), .rst_n(rst_n), .run(run), .a(dec_a), .b(dec_b),
      .mode(qmode_e'(cfg_mode)), .up(st_up), .dn(st_dn), .err(st_err)
   );

   qenc_capture #(.DLY_W(DLY_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .run(run), .strobe(cap_strobe),
      .delay(cap_delay), .fire(cap_fire)
   );

   assign idx_hit = run & flt[2] & ~idx_q;
   assign reload  = idx_hit & cfg_idx_reload;
   assign stepped = (st_up | st_dn) & ~reload;

   always_comb begin
      pos_n   = pos;
      wrapped = 1'b0;
      if (reload) begin
         pos_n = init_val;
      end else if (st_up) begin
         if (cfg_wrap_en && pos == max_val) begin
            pos_n   = init_val;
            wrapped = 1'b1;
         end else begin
            pos_n = pos + 1'b1;
         end
      end else if (st_dn) begin
         if (cfg_wrap_en && pos == init_val) begin
            pos_n   = max_val;
            wrapped = 1'b1;
         end else begin
            pos_n = pos - 1'b1;
         end
      end
   end

   always_comb begin
      fset          = '0;
      fset[FL_IDX]  = idx_hit;
      fset[FL_QERR] = st_err;
      fset[FL_CMP]  = stepped & (pos_n == cmp_val);
      fset[FL_WRAP] = stepped & wrapped;
      fset[FL_CAP]  = cap_fire;
      fset[FL_DIR]  = stepped & (st_up != dir);
      fset[FL_MOVE] = stepped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= '0;
         idx_pos <= '0;
         cap_pos <= '0;
         dir     <= 1'b0;
         idx_q   <= 1'b0;
      end else if (run) begin
         pos   <= pos_n;
         idx_q <= flt[2];
         if (idx_hit)  idx_pos <= pos;
         if (cap_fire) cap_pos <= pos;
         if (stepped)  dir     <= st_up;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags <= '0;
      else if (!run)       flags <= cfg_sticky ? (flags & ~flag_clr) : '0;
      else                 flags <= (flags & ~flag_clr) | fset;
   end

   assign irq = |(flags & irq_mask);
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk
   import qenc_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_enable,
   input logic             cfg_sticky,
   input logic             cfg_wrap_en,
   input logic             cfg_idx_reload,
   input logic [CNT_W-1:0] max_val,
   input logic [CNT_W-1:0] init_val,
   input logic [NFLAG-1:0] flag_clr,
   input logic [CNT_W-1:0] pos,
   input logic [CNT_W-1:0] idx_pos,
   input logic [CNT_W-1:0] cap_pos,
   input logic [NFLAG-1:0] flags
);
   // R14
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> $stable(pos));

   // R14
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sticky && !cfg_enable && flag_clr == '0) |=> flags == $past(flags));

   // R14
   nonsticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sticky && !cfg_enable) |=> flags == '0);

   // R11
   cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_pos) |-> flags[FL_CAP]);

   // R8
   idx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(idx_pos) |-> flags[FL_IDX]);

   // R7
   qerr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags[FL_QERR]) && !$past(cfg_idx_reload)) |-> $stable(pos));

   // R9
   wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_wrap_en) && $stable(max_val) && $stable(init_val) &&
       $past(pos) == $past(max_val) && !$stable(pos))
      |-> (pos == init_val || pos == max_val - 1'b1));
endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_sticky(cfg_sticky),
   .cfg_wrap_en(cfg_wrap_en), .cfg_idx_reload(cfg_idx_reload),
   .max_val(max_val), .init_val(init_val), .flag_clr(flag_clr),
   .pos(pos), .idx_pos(idx_pos), .cap_pos(cap_pos), .flags(flags)
);

// File: tb/qenc_counter_tb.sv
module qenc_counter_tb;
   localparam int SETTLE = 12;
   localparam int S_POS = 0, S_IDX = 1, S_CAP = 2, S_DIR = 3, S_FLG = 4, S_IRQ = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0;
   logic [1:0]  cfg_mode = 2'd2;
   logic        cfg_swap = 1'b0;
   logic [1:0]  cfg_filt = 2'd0;
   logic [2:0]  cfg_presc = 3'd0;
   logic        cfg_idx_reload = 1'b0;
   logic        cfg_wrap_en = 1'b0;
   logic        cfg_sticky = 1'b0;
   logic [31:0] max_val = 32'd0;
   logic [31:0] init_val = 32'd0;
   logic [31:0] cmp_val = 32'hFFFF_FFFF;
   logic [31:0] cap_delay = 32'd0;
   logic        ch_a = 1'b0, ch_b = 1'b0, ch_idx = 1'b0, cap_strobe = 1'b0;
   logic [6:0]  flag_clr = 7'd0;
   logic [6:0]  irq_mask = 7'd0;
   logic [31:0] pos, idx_pos, cap_pos;
   logic        dir, irq;
   logic [6:0]  flags;

   int checks = 0;
   int errors = 0;
   int phase = 0;
   bit done = 0;

   int          sel_q[$];
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   qenc_counter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
      .cfg_swap(cfg_swap), .cfg_filt(cfg_filt), .cfg_presc(cfg_presc),
      .cfg_idx_reload(cfg_idx_reload), .cfg_wrap_en(cfg_wrap_en),
      .cfg_sticky(cfg_sticky), .max_val(max_val), .init_val(init_val),
      .cmp_val(cmp_val), .cap_delay(cap_delay), .ch_a(ch_a), .ch_b(ch_b),
      .ch_idx(ch_idx), .cap_strobe(cap_strobe), .flag_clr(flag_clr),
      .irq_mask(irq_mask), .pos(pos), .idx_pos(idx_pos), .cap_pos(cap_pos),
      .dir(dir), .flags(flags), .irq(irq)
   );

   function automatic logic [31:0] observe(input int sel);
      case (sel)
         S_POS:   return pos;
         S_IDX:   return idx_pos;
         S_CAP:   return cap_pos;
         S_DIR:   return {31'd0, dir};
         S_FLG:   return {25'd0, flags};
         default: return {31'd0, irq};
      endcase
   endfunction

   // monitor: pops queued expectations and compares on a falling edge
   always @(negedge clk) begin
      while (sel_q.size() > 0) begin
         int          s;
         logic [31:0] e;
         string       t;
         logic [31:0] got;
         s = sel_q.pop_front();
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         got = observe(s);
         checks++;
         if (got !== e) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", t, got, e);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_v(input int sel, input logic [31:0] v, input string tag);
      sel_q.push_back(sel);
      exp_q.push_back(v);
      tag_q.push_back(tag);
      tick(2);
   endtask

   task automatic drive_phase();
      case (phase)
         0: {ch_a, ch_b} = 2'b00;
         1: {ch_a, ch_b} = 2'b10;
         2: {ch_a, ch_b} = 2'b11;
         default: {ch_a, ch_b} = 2'b01;
      endcase
   endtask

   task automatic quad(input int n, input bit fwd);
      for (int i = 0; i < n; i++) begin
         phase = fwd ? (phase + 1) % 4 : (phase + 3) % 4;
         drive_phase();
         tick(SETTLE);
      end
   endtask

   task automatic clear_all();
      flag_clr = 7'h7F;
      tick(1);
      flag_clr = 7'h00;
      tick(1);
   endtask

   task automatic pulse_idx();
      ch_idx = 1'b1;
      tick(6);
      ch_idx = 1'b0;
      tick(SETTLE);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R14 reset state
      expect_v(S_POS, 0, "R14 reset pos");
      expect_v(S_FLG, 0, "R14 reset flags");
      expect_v(S_IRQ, 0, "R14 reset irq");

      cfg_enable = 1'b1;
      tick(4);
      quad(8, 1);
      expect_v(S_POS, 8, "R1 x4 up");
      expect_v(S_DIR, 1, "R12 dir up");
      expect_v(S_FLG, 7'h60, "R12 move and dir change flags");
      clear_all();
      quad(3, 0);
      expect_v(S_POS, 5, "R1 x4 down");
      expect_v(S_DIR, 0, "R12 dir down");
      clear_all();

      cfg_mode = 2'd1;
      quad(4, 1);
      expect_v(S_POS, 7, "R2 x2 up");
      cfg_mode = 2'd0;
      quad(4, 1);
      expect_v(S_POS, 8, "R3 x1 up");
      quad(4, 0);
      expect_v(S_POS, 7, "R3 x1 down");

      cfg_mode = 2'd2;
      quad(3, 1);
      expect_v(S_POS, 10, "R1 x4 realign");
      cfg_swap = 1'b1;
      tick(SETTLE);
      quad(2, 1);
      expect_v(S_POS, 8, "R4 swapped counts down");
      cfg_swap = 1'b0;
      tick(SETTLE);
      clear_all();

      // R7: both phases change together (11 -> 00)
      phase = 0;
      drive_phase();
      tick(SETTLE);
      expect_v(S_FLG, 7'h02, "R7 qerr flag");
      expect_v(S_POS, 8, "R7 count held");
      clear_all();

      // R5: 2-clock glitch against a 4-sample filter
      cfg_filt = 2'd3;
      tick(SETTLE);
      ch_a = 1'b1;
      tick(2);
      ch_a = 1'b0;
      tick(SETTLE);
      expect_v(S_POS, 8, "R5 glitch rejected");
      expect_v(S_FLG, 0, "R5 no movement flag");
      quad(1, 1);
      expect_v(S_POS, 9, "R5 long change accepted");
      cfg_filt = 2'd0;

      // R6: divide by 16 with a 4-sample filter
      cfg_filt = 2'd3;
      cfg_presc = 3'd4;
      tick(SETTLE);
      phase = 2;
      drive_phase();
      tick(20);
      expect_v(S_POS, 9, "R6 not yet accepted");
      tick(150);
      expect_v(S_POS, 10, "R6 accepted after slow samples");
      cfg_filt = 2'd0;
      cfg_presc = 3'd0;
      tick(SETTLE);
      clear_all();

      pulse_idx();
      expect_v(S_IDX, 10, "R8 index latch");
      expect_v(S_POS, 10, "R8 no reload");
      expect_v(S_FLG, 7'h01, "R8 index flag");
      clear_all();
      init_val = 32'd20;
      cfg_idx_reload = 1'b1;
      pulse_idx();
      expect_v(S_POS, 20, "R8 reload on index");
      expect_v(S_IDX, 10, "R8 latch before reload");
      cfg_idx_reload = 1'b0;
      clear_all();

      max_val = 32'd23;
      cfg_wrap_en = 1'b1;
      tick(2);
      quad(4, 1);
      expect_v(S_POS, 20, "R9 wrap up to init");
      expect_v(S_FLG, 7'h48, "R9 wrap flag up");
      clear_all();
      quad(1, 0);
      expect_v(S_POS, 23, "R9 wrap down to max");
      expect_v(S_FLG, 7'h68, "R9 wrap flag down");
      clear_all();

      cmp_val = 32'd22;
      tick(1);
      quad(1, 0);
      expect_v(S_FLG, 7'h44, "R10 compare flag");
      irq_mask = 7'h04;
      tick(1);
      expect_v(S_IRQ, 1, "R13 irq on masked flag");
      irq_mask = 7'h08;
      tick(1);
      expect_v(S_IRQ, 0, "R13 irq masked off");
      clear_all();
      expect_v(S_FLG, 0, "R13 write-one clear");

      cap_delay = 32'd5;
      tick(1);
      cap_strobe = 1'b1;
      tick(3);
      cap_strobe = 1'b0;
      tick(3);
      expect_v(S_FLG, 0, "R11 capture not before delay");
      tick(6);
      expect_v(S_FLG, 7'h10, "R11 capture flag");
      expect_v(S_CAP, 22, "R11 capture value");

      cfg_enable = 1'b0;
      tick(2);
      expect_v(S_FLG, 0, "R14 flags cleared when disabled");
      quad(1, 1);
      expect_v(S_POS, 22, "R14 frozen while disabled");
      cfg_enable = 1'b1;
      tick(SETTLE);
      expect_v(S_POS, 23, "R14 resumes on enable");
      cfg_sticky = 1'b1;
      cfg_enable = 1'b0;
      tick(2);
      expect_v(S_FLG, 7'h60, "R14 sticky keeps flags");
      flag_clr = 7'h20;
      tick(1);
      flag_clr = 7'h00;
      tick(1);
      expect_v(S_FLG, 7'h40, "R13 clear while disabled sticky");

      tick(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule